// File: doc/BRIEF.md
# Stereo Audio Transmit Queue Controller

This block holds decoded stereo samples between the CPU that produces them and a serializer that drives an external audio converter. Left and right samples go into separate first-in, first-out queues of eight entries each. Software switches each queue on with its own enable bit. A status register shows an acknowledge bit for each enable, and software waits for that bit before it writes samples. Writes to a full queue and pops from an empty queue set sticky error flags. Software clears these flags by writing ones to them.

The CPU uses a small register port: a write strobe, a 3-bit address, 32-bit write data and a combinational read-data bus. The serializer pulls samples with one pop strobe per channel. The head sample of that channel is presented combinationally in the same cycle as the strobe.

The interrupt output is a registered level. It depends only on how full the right queue is. It asserts when the right queue holds half of its capacity or less and both masks are open: the source mask in the control register and the separate global unmask. Opening the masks while the queue is empty therefore raises the line at once, with no sample written first.

Top module: `stereo_txq`

## Requirements
- R1: Each queue holds up to 8 samples. A write to address 2 pushes the left queue and a write to address 3 pushes the right queue, taking data from write bits [15:0]. The status register at address 1 reports the left occupancy in bits [11:8] and the right occupancy in bits [19:16].
- R2: Samples leave each queue in write order. While a pop strobe is high, the head sample of that queue is shown on its data output, and the sample is removed at the next clock edge.
- R3: A push to a full, acknowledged queue drops the data and sets a sticky overrun flag: status bit 2 for left, bit 3 for right.
- R4: A pop from an empty, acknowledged queue returns zero and sets a sticky underrun flag: status bit 4 for left, bit 5 for right.
- R5: Writing the status register clears each flag whose write bit is 1 and leaves the other flags unchanged. Writing all ones clears every flag.
- R6: Control bits 0 and 1 (address 0) enable the left and right queues. Status bits 0 and 1 become set one clock after the enable register. While a channel's acknowledge bit is 0, pushes to that channel are ignored.
- R7: Clearing a channel's enable bit empties its queue and clears its acknowledge bit on the next clock.
- R8: The interrupt is high one clock after the following conditions hold: the global unmask (address 4, bit 0) is 1, the source mask (control bit 2) is 1, and the right occupancy is 4 or less. This includes an empty right queue.
- R9: The interrupt drops one clock after the right occupancy exceeds 4 or either mask is cleared.
- R10: The control register and the unmask register read back their written values, and all registers read as 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for cpu_addr |
| ser_pop_l | input | 1 | Serializer pop, left queue |
| ser_pop_r | input | 1 | Serializer pop, right queue |
| ser_data_l | output | 16 | Left head sample, zero when empty |
| ser_data_r | output | 16 | Right head sample, zero when empty |
| irq | output | 1 | Level interrupt, right queue at or below half |

## Verification
The bench fills each queue with every occupancy from 0 to 9 and then drains it. At each step it checks the occupancy and the interrupt level, and whether the overrun and underrun flags are set. A threshold off by one would make the interrupt wrong at exactly four or five entries. A full test off by one would either accept a ninth sample or drop the eighth. The bench also pops an empty queue and checks that zero is returned rather than stale data. It clears a single flag and checks that its neighbours survive. It writes to a disabled queue and checks that the write leaves no trace. Finally, it disables a loaded queue and checks that the queue comes back empty.

// File: rtl/stereo_txq_pkg.sv
package stereo_txq_pkg;
  localparam int SAMPLE_W = 16;
  localparam int Q_DEPTH  = 8;

  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_STAT  = 3'd1,
    ADDR_PUSHL = 3'd2,
    ADDR_PUSHR = 3'd3,
    ADDR_UNMSK = 3'd4
  } txq_addr_e;

  localparam int BIT_ACK = 0;
  localparam int BIT_OVR = 2;
  localparam int BIT_UDR = 4;
  localparam int BIT_SRC = 2;
  localparam int CNT_LO_L = 8;
  localparam int CNT_LO_R = 16;
endpackage

// File: rtl/stereo_txq_chan.sv
module stereo_txq_chan #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  input  logic             clr_ovr_i,
  input  logic             clr_udr_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] count_o,
  output logic [DW-1:0]    head_o,
  output logic             ovr_o,
  output logic             udr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ack_q, ovr_q, ovr_n, udr_q, udr_n;
  logic [DW-1:0]    mem_q [DEPTH];
  logic             full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == FULL_C);
  assign empty   = (cnt_q == '0);
  assign push_ok = ack_q & push_i & ~full;
  assign pop_ok  = ack_q & pop_i & ~empty;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (!en_i) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (push_ok) wr_ptr_n = (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_n = (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
      cnt_n = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
    ovr_n = (ovr_q & ~clr_ovr_i) | (ack_q & push_i & full);
    udr_n = (udr_q & ~clr_udr_i) | (ack_q & pop_i & empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      ovr_q    <= 1'b0;
      udr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
      ack_q    <= en_i;
      ovr_q    <= ovr_n;
      udr_q    <= udr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign ack_o   = ack_q;
  assign count_o = cnt_q;
  assign ovr_o   = ovr_q;
  assign udr_o   = udr_q;
endmodule

// File: rtl/stereo_txq_irq.sv
module stereo_txq_irq #(
  parameter int CNT_W  = 4,
  parameter int THRESH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unmask_i,
  input  logic             src_en_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] THR_C = CNT_W'(THRESH);
  logic irq_q, irq_n;

  always_comb irq_n = unmask_i & src_en_i & (level_i <= THR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/stereo_txq.sv
module stereo_txq
  import stereo_txq_pkg::*;
#(
  parameter int DEPTH = Q_DEPTH,
  parameter int DW    = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  input  logic          ser_pop_l,
  input  logic          ser_pop_r,
  output logic [DW-1:0] ser_data_l,
  output logic [DW-1:0] ser_data_r
  ,output logic         irq
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int THRESH = DEPTH / 2;

  logic [1:0] ch_en_q, ch_en_n;
  logic       src_en_q, src_en_n, gie_q, gie_n;
  logic       ctrl_wr, stat_wr, unmsk_wr;
  logic [1:0] push, pop, ack, ovr, udr;
  logic [CNT_W-1:0] cnt_l, cnt_r;
  logic [DW-1:0]    head [2];
  logic [CNT_W-1:0] cnt  [2];
  logic unused_wdata;

  assign unused_wdata = ^cpu_wdata;
  assign ctrl_wr  = cpu_wr & (cpu_addr == ADDR_CTRL);
  assign stat_wr  = cpu_wr & (cpu_addr == ADDR_STAT);
  assign unmsk_wr = cpu_wr & (cpu_addr == ADDR_UNMSK);
  assign push[0]  = cpu_wr & (cpu_addr == ADDR_PUSHL);
  assign push[1]  = cpu_wr & (cpu_addr == ADDR_PUSHR);
  assign pop      = {ser_pop_r, ser_pop_l};

  always_comb begin
    ch_en_n  = ch_en_q;
    src_en_n = src_en_q;
    gie_n    = gie_q;
    if (ctrl_wr) begin
      ch_en_n  = cpu_wdata[1:0];
      src_en_n = cpu_wdata[BIT_SRC];
    end
    if (unmsk_wr) gie_n = cpu_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en_q  <= '0;
      src_en_q <= 1'b0;
      gie_q    <= 1'b0;
    end else begin
      ch_en_q  <= ch_en_n;
      src_en_q <= src_en_n;
      gie_q    <= gie_n;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    stereo_txq_chan #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ch_en_q[c]),
      .push_i    (push[c]),
      .wdata_i   (cpu_wdata[DW-1:0]),
      .pop_i     (pop[c]),
      .clr_ovr_i (stat_wr & cpu_wdata[BIT_OVR + c]),
      .clr_udr_i (stat_wr & cpu_wdata[BIT_UDR + c]),
      .ack_o     (ack[c]),
      .count_o   (cnt[c]),
      .head_o    (head[c]),
      .ovr_o     (ovr[c]),
      .udr_o     (udr[c])
    );
  end

  assign cnt_l      = cnt[0];
  assign cnt_r      = cnt[1];
  assign ser_data_l = head[0];
  assign ser_data_r = head[1];

  stereo_txq_irq #(.CNT_W(CNT_W), .THRESH(THRESH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .unmask_i (gie_q),
    .src_en_i (src_en_q),
    .level_i  (cnt_r),
    .irq_o    (irq)
  );

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      ADDR_CTRL:  cpu_rdata[2:0] = {src_en_q, ch_en_q};
      ADDR_STAT: begin
        cpu_rdata[BIT_ACK +: 2]        = ack;
        cpu_rdata[BIT_OVR +: 2]        = ovr;
        cpu_rdata[BIT_UDR +: 2]        = udr;
        cpu_rdata[CNT_LO_L +: CNT_W]   = cnt_l;
        cpu_rdata[CNT_LO_R +: CNT_W]   = cnt_r;
      end
      ADDR_UNMSK: cpu_rdata[0] = gie_q;
      default:    cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stereo_txq_chk.sv
module stereo_txq_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [2:0]       cpu_addr,
  input logic [31:0]      cpu_wdata,
  input logic [1:0]       ch_en,
  input logic             src_en,
  input logic             gie,
  input logic [CNT_W-1:0] cnt_l,
  input logic [CNT_W-1:0] cnt_r,
  input logic [1:0]       ovr,
  input logic             ser_pop_l,
  input logic [DW-1:0]    ser_data_l,
  input logic             irq
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);
  logic stat_clr_l;
  assign stat_clr_l = cpu_wr && (cpu_addr == 3'd1) && cpu_wdata[2];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_l <= FULL_C) && (cnt_r <= FULL_C)); // R1
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pop_l && cnt_l == '0) |-> (ser_data_l == '0)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr[0] && !stat_clr_l) |=> ovr[0]); // R5
  AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |=> (cnt_l == '0)); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && src_en && cnt_r <= HALF_C) |=> irq); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || !src_en || cnt_r > HALF_C) |=> !irq); // R9
endmodule

bind stereo_txq stereo_txq_chk #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .ch_en      (ch_en_q),
  .src_en     (src_en_q),
  .gie        (gie_q),
  .cnt_l      (cnt_l),
  .cnt_r      (cnt_r),
  .ovr        (ovr),
  .ser_pop_l  (ser_pop_l),
  .ser_data_l (ser_data_l),
  .irq        (irq)
);

// File: tb/stereo_txq_test.sv
module stereo_txq_test;
  logic        clk, rst_n, cpu_wr, ser_pop_l, ser_pop_r;
  logic [2:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic [15:0] ser_data_l, ser_data_r;
  logic        irq;
  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  stereo_txq uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic popc(input int ch, output logic [15:0] d);
    @(negedge clk);
    if (ch == 0) ser_pop_l = 1'b1; else ser_pop_r = 1'b1;
    #1 d = (ch == 0) ? ser_data_l : ser_data_r;
    @(negedge clk);
    ser_pop_l = 1'b0; ser_pop_r = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int ch, input int n, input int i);
    return 16'((ch << 12) | (n << 4) | i + 16'h0a00);
  endfunction

  initial begin
    logic [31:0] s;
    logic [15:0] d;
    cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; ser_pop_l = 0; ser_pop_r = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    rd(3'd1, s); chk("R10 status after reset", s, 32'h0);
    rd(3'd0, s); chk("R10 ctrl after reset", s, 32'h0);
    rd(3'd4, s); chk("R10 unmask after reset", s, 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);

    // R6 disabled queue ignores pushes
    wr(3'd2, 32'h1234); wr(3'd2, 32'h1234);
    rd(3'd1, s); chk("R6 push ignored while disabled", s, 32'h0);

    // R8 unmask with empty right queue raises irq
    wr(3'd0, 32'h6);
    wr(3'd4, 32'h1);
    tick();
    chk("R8 irq on empty unmask", {31'b0, irq}, 32'h1);
    rd(3'd0, s); chk("R10 ctrl readback", s, 32'h6);
    rd(3'd4, s); chk("R10 unmask readback", s, 32'h1);
    wr(3'd0, 32'h7); tick();
    rd(3'd1, s); chk("R6 both acks set", s[1:0], 32'h3);

    // Occupancy sweep per channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n <= 9; n++) begin
        int k;
        k = (n > 8) ? 8 : n;
        wr(3'd0, 32'h7 & ~(32'h1 << ch));
        tick();
        rd(3'd1, s); chk("R7 flushed and ack low", {s[ch], 3'b0, (ch == 0) ? s[11:8] : s[19:16]}, 32'h0);
        wr(3'd0, 32'h7); tick();
        for (int i = 0; i < n; i++) wr(3'(2 + ch), {16'hdead, pat(ch, n, i)});
        rd(3'd1, s);
        chk($sformatf("R1 level ch%0d n%0d", ch, n), (ch == 0) ? s[11:8] : s[19:16], 32'(k));
        chk($sformatf("R3 overrun ch%0d n%0d", ch, n), s[2 + ch], 32'(n > 8));
        if (ch == 1) begin
          tick();
          chk($sformatf("R8 R9 irq level n%0d", n), {31'b0, irq}, 32'(n <= 4));
        end
        for (int i = 0; i < k; i++) begin
          popc(ch, d);
          chk($sformatf("R2 order ch%0d n%0d i%0d", ch, n, i), d, pat(ch, n, i));
        end
        rd(3'd1, s); chk("R4 no underrun yet", s[4 + ch], 32'h0);
        popc(ch, d);
        chk("R4 empty pop returns zero", d, 32'h0);
        rd(3'd1, s); chk("R4 underrun set", s[4 + ch], 32'h1);
        wr(3'd1, 32'hffff_ffff);
        rd(3'd1, s); chk("R5 all flags cleared", s[5:2], 32'h0);
      end
    end

    // R5 selective clear: set left overrun and right underrun
    for (int i = 0; i < 9; i++) wr(3'd2, 32'(i));
    popc(1, d);
    rd(3'd1, s); chk("R5 flags set", {s[5], s[2]}, 32'h3);
    wr(3'd1, 32'h4);
    rd(3'd1, s); chk("R5 only bit2 cleared", {s[5], s[2]}, 32'h2);
    wr(3'd1, 32'h20);
    rd(3'd1, s); chk("R5 bit5 cleared", s[5:2], 32'h0);

    // R7 flush of a loaded left queue
    wr(3'd0, 32'h6); tick();
    rd(3'd1, s); chk("R7 loaded queue flushed", {s[11:8], 3'b0, s[0]}, 32'h0);
    popc(0, d); chk("R7 flushed head zero", d, 32'h0);

    // R9 masks drop irq
    wr(3'd0, 32'h7); tick();
    wr(3'd3, 32'h1);
    tick();
    chk("R8 irq with one entry", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h3); tick();
    chk("R9 source mask drops irq", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h7); tick();
    chk("R8 irq back", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0); tick();
    chk("R9 global mask drops irq", {31'b0, irq}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule